// File: doc/BRIEF.md
# Four-Tap LMS Adaptive FIR Filter

This block is a fixed-point adaptive transversal filter. Each accepted input pair consists of a signed sample `x` and a signed desired value `d`. The filter forms an output from the current sample and the three samples before it, each scaled by its own tap weight. The error is the desired value minus that output. Every tap weight then takes one least-mean-square step toward a smaller error.

The step size is a power of two, 2^-SHIFT, fixed at elaboration time. Samples, weights, the output and the error are all signed Q1.15 values.

Each weight update is built in redundant form. The shifted old weight, the error-times-sample product and a rounding constant pass through one 3:2 carry-save layer. A single carry-propagate adder then resolves the result, so each tap has only one full-width adder. The intended uses are in-line system identification, echo cancellation and noise cancellation, where one new sample arrives with each strobe.

Top module: `lms_adaptive_fir`

## Requirements
- R1: A synchronous reset clears `yOut`, `errOut` and `outValid` to 0 and clears all four weights and the three delay-line stages to 0. The first sample accepted after reset therefore gives `yOut` = 0 and `errOut` = sat(d).
- R2: `outValid` is high in the cycle after each cycle in which `inValid` is high. It is low in the cycle after each cycle in which `inValid` is low.
- R3: `yOut` = sat16(floor((Σ w_k·x(n−k) + 2^14) / 2^15)) for k = 0..3. Here x(n) is the sample presented with the strobe, x(n−k) is the sample accepted k strobes earlier, and w_k holds the values left by the previous strobe.
- R4: `errOut` = sat16(d(n) − yOut(n)), where `yOut(n)` is the output of R3 from the same strobe.
- R5: On each strobe, every weight becomes w_k' = sat16(w_k + floor((e·x(n−k) + 2^(14+SHIFT)) / 2^(15+SHIFT))). The new weights apply from the next strobe. For example, with SHIFT=4 and starting from reset: a strobe (x=16384, d=16384), then a strobe (0, 0), then a strobe (16384, 0) gives `yOut`=256 and `errOut`=−256 on the third strobe.
- R6: While `inValid` is low, the weights, the delay line, `yOut` and `errOut` keep their values, and the values on `xIn` and `dIn` have no effect.
- R7: When d(n) = x(n)/2 and x is white, the filter identifies the system. After 4000 samples of amplitude up to ±8191, |errOut| stays below 256.
- R8: Results that fall outside the Q1.15 range clamp to 32767 or −32768. For example, if `yOut` is ≤ 0 and d = 32767, then `errOut` = 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe: accept `xIn`, `dIn` this cycle |
| xIn | input | 16 | Input sample, signed Q1.15 |
| dIn | input | 16 | Desired sample, signed Q1.15 |
| yOut | output | 16 | Filter output, signed Q1.15 |
| errOut | output | 16 | Error d − y, signed Q1.15 |
| outValid | output | 1 | `yOut`/`errOut` belong to the previous cycle's strobe |

## Verification
A sample strobed at one rising edge produces `yOut`, `errOut` and `outValid` at that same edge, and the weights it updates take effect at the next strobe. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and compares the outputs on the following falling edge. Its expected values come from an integer model advanced once per strobe. During idle gaps the bench samples every cycle to confirm that `outValid` is low and that the outputs hold. The next strobe after the gap is then compared with a model that was not advanced, which shows that the hidden weights and delay line stayed the same.

// File: rtl/lms_pkg.sv
package lms_pkg;
  // strobes issued by the sequencer to the arithmetic path
  typedef struct packed {
    logic shiftLine;   // advance the tapped delay line
    logic adaptTaps;   // commit the updated weights
    logic loadOut;     // register output and error
  } lms_ctl_t;
endpackage

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output lms_ctl_t ctl,
  output logic     outValid
);
  always_comb begin
    ctl.shiftLine = inValid;
    ctl.adaptTaps = inValid;
    ctl.loadOut   = inValid;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/lms_tap_update.sv
module lms_tap_update #(
  parameter int W     = 16,
  parameter int SHIFT = 4
) (
  input  logic signed [W-1:0] wCur,
  input  logic signed [W-1:0] xTap,
  input  logic signed [W-1:0] errNow,
  output logic signed [W-1:0] wNew
);
  localparam int FRAC   = W - 1;
  localparam int PROD_W = 2 * W;
  localparam int SH     = FRAC + SHIFT;
  localparam int UPD_W  = W + SH + 2;
  localparam logic signed [UPD_W-1:0] W_MAX  = UPD_W'((2 ** (W - 1)) - 1);
  localparam logic signed [UPD_W-1:0] W_MIN  = -W_MAX - UPD_W'(1);
  localparam logic signed [UPD_W-1:0] RND_C  = UPD_W'(1) << (SH - 1);

  logic signed [PROD_W-1:0] prodE;
  logic signed [UPD_W-1:0]  opA, opB;
  logic signed [UPD_W-1:0]  csaSum, csaCarry, total, scaled;

  assign prodE = errNow * xTap;
  assign opA   = UPD_W'(wCur) <<< SH;
  assign opB   = UPD_W'(prodE);

  // 3:2 carry-save layer: old weight, step product, rounding constant
  assign csaSum   = opA ^ opB ^ RND_C;
  assign csaCarry = ((opA & opB) | (opA & RND_C) | (opB & RND_C)) << 1;

  // single carry-propagate resolution
  assign total  = csaSum + csaCarry;
  assign scaled = total >>> SH;

  always_comb begin
    if (scaled > W_MAX)      wNew = W_MAX[W-1:0];
    else if (scaled < W_MIN) wNew = W_MIN[W-1:0];
    else                     wNew = scaled[W-1:0];
  end
endmodule

// File: rtl/lms_datapath.sv
module lms_datapath
  import lms_pkg::*;
#(
  parameter int W     = 16,
  parameter int TAPS  = 4,
  parameter int SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  lms_ctl_t            ctl,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] dIn,
  output logic signed [W-1:0] yOut,
  output logic signed [W-1:0] errOut
);
  localparam int FRAC   = W - 1;
  localparam int PROD_W = 2 * W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS) + 1;
  localparam logic signed [ACC_W-1:0] Y_MAX  = ACC_W'((2 ** (W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN  = -Y_MAX - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] Y_HALF = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [W:0]       E_MAX  = (W+1)'((2 ** (W - 1)) - 1);
  localparam logic signed [W:0]       E_MIN  = -E_MAX - (W+1)'(1);

  logic signed [W-1:0]      delayLine [TAPS-1];
  logic signed [W-1:0]      weight    [TAPS];
  logic signed [W-1:0]      weightNxt [TAPS];
  logic signed [W-1:0]      tapX      [TAPS];
  logic signed [PROD_W-1:0] prod      [TAPS];
  logic signed [ACC_W-1:0]  acc, accRnd;
  logic signed [W-1:0]      yNext, eNext;
  logic signed [W:0]        eWide;

  assign tapX[0] = xIn;

  generate
    for (genvar k = 1; k < TAPS; k++) begin : g_tapx
      assign tapX[k] = delayLine[k-1];
    end
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign prod[k] = weight[k] * tapX[k];
      lms_tap_update #(.W(W), .SHIFT(SHIFT)) i_upd (
        .wCur  (weight[k]),
        .xTap  (tapX[k]),
        .errNow(eNext),
        .wNew  (weightNxt[k])
      );
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod[k]);
  end

  assign accRnd = (acc + Y_HALF) >>> FRAC;

  always_comb begin
    if (accRnd > Y_MAX)      yNext = Y_MAX[W-1:0];
    else if (accRnd < Y_MIN) yNext = Y_MIN[W-1:0];
    else                     yNext = accRnd[W-1:0];
  end

  assign eWide = (W+1)'(dIn) - (W+1)'(yNext);

  always_comb begin
    if (eWide > E_MAX)      eNext = E_MAX[W-1:0];
    else if (eWide < E_MIN) eNext = E_MIN[W-1:0];
    else                    eNext = eWide[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS - 1; k++) delayLine[k] <= '0;
      for (int k = 0; k < TAPS; k++)     weight[k]    <= '0;
      yOut   <= '0;
      errOut <= '0;
    end else begin
      if (ctl.shiftLine) begin
        delayLine[0] <= xIn;
        for (int k = 1; k < TAPS - 1; k++) delayLine[k] <= delayLine[k-1];
      end
      if (ctl.adaptTaps)
        for (int k = 0; k < TAPS; k++) weight[k] <= weightNxt[k];
      if (ctl.loadOut) begin
        yOut   <= yNext;
        errOut <= eNext;
      end
    end
  end
endmodule

// File: rtl/lms_adaptive_fir.sv
module lms_adaptive_fir
  import lms_pkg::*;
#(
  parameter int W     = 16,
  parameter int TAPS  = 4,
  parameter int SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] dIn,
  output logic signed [W-1:0] yOut,
  output logic signed [W-1:0] errOut,
  output logic                outValid
);
  lms_ctl_t ctl;

  lms_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctl     (ctl),
    .outValid(outValid)
  );

  lms_datapath #(.W(W), .TAPS(TAPS), .SHIFT(SHIFT)) i_dp (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .xIn   (xIn),
    .dIn   (dIn),
    .yOut  (yOut),
    .errOut(errOut)
  );
endmodule

// File: rtl/lms_fir_checker.sv
module lms_fir_checker #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic signed [W-1:0] dIn,
  input logic signed [W-1:0] yOut,
  input logic signed [W-1:0] errOut,
  input logic                outValid
);
  function automatic logic signed [W-1:0] satDiff(input logic signed [W-1:0] a,
                                                  input logic signed [W-1:0] b);
    logic signed [W:0] t;
    t = (W+1)'(a) - (W+1)'(b);
    if (t > (W+1)'((2 ** (W - 1)) - 1))  return W'((2 ** (W - 1)) - 1);
    if (t < -(W+1)'(2 ** (W - 1)))       return W'(-(2 ** (W - 1)));
    return t[W-1:0];
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (yOut == '0 && errOut == '0 && !outValid));

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_error_sat_r4: assert property (@(posedge clk) disable iff (rst)
    outValid |-> errOut == satDiff($past(dIn), yOut));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(yOut) && $stable(errOut)));
endmodule

bind lms_adaptive_fir lms_fir_checker #(.W(W)) i_lms_fir_checker (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .dIn     (dIn),
  .yOut    (yOut),
  .errOut  (errOut),
  .outValid(outValid)
);

// File: tb/test_lms_adaptive_fir.sv
module test_lms_adaptive_fir;
  localparam int PERIOD = 10;
  localparam int SH     = 4;
  localparam int NTAB   = 12;
  localparam int TBL [NTAB][2] = '{
    '{ 12000,   3000}, '{ -8000,   9000}, '{ 32767,  32767}, '{-32768, -32768},
    '{     0,  20000}, '{  1234,  -4321}, '{ 16384, -16384}, '{ -1000,    700},
    '{ 32767, -32768}, '{-32768,  32767}, '{   255,      1}, '{ -2048,  -2048}
  };

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0;
  logic signed [15:0] xIn = '0, dIn = '0;
  logic signed [15:0] yOut, errOut;
  logic outValid;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  int mW[4];
  int mD[3];

  always #(PERIOD/2) clk = ~clk;

  lms_adaptive_fir i_lms_adaptive_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .xIn(xIn), .dIn(dIn),
    .yOut(yOut), .errOut(errOut), .outValid(outValid)
  );

  function automatic int sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 4; k++) mW[k] = 0;
    for (int k = 0; k < 3; k++) mD[k] = 0;
  endtask

  task automatic modelStep(int x, int d, output int ey, output int ee);
    longint acc;
    int xv[4];
    xv[0] = x; xv[1] = mD[0]; xv[2] = mD[1]; xv[3] = mD[2];
    acc = 0;
    for (int k = 0; k < 4; k++) acc += longint'(mW[k]) * xv[k];
    ey = sat16((acc + 16384) >>> 15);
    ee = sat16(longint'(d) - ey);
    for (int k = 0; k < 4; k++)
      mW[k] = sat16(mW[k] + ((longint'(ee) * xv[k] + (longint'(1) <<< (14 + SH))) >>> (15 + SH)));
    mD[2] = mD[1]; mD[1] = mD[0]; mD[0] = x;
  endtask

  // called at a falling edge; returns at the next falling edge with results visible
  task automatic apply(int x, int d, string req, output int ey, output int ee);
    xIn = 16'(x); dIn = 16'(d); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    modelStep(x, d, ey, ee);
    check({req, " y"}, int'(yOut), ey);
    check({req, " e"}, int'(errOut), ee);
    check("R2 outValid", int'(outValid), 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ey, ee;
    int maxErr;
    logic [15:0] lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 y", int'(yOut), 0);
    check("R1 e", int'(errOut), 0);
    check("R1 outValid", int'(outValid), 0);
    rst = 1'b0;
    @(negedge clk);

    // R5: hand-worked adaptation sequence
    apply(16384, 16384, "R1 first", ey, ee);
    check("R1 first e", int'(errOut), 16384);
    apply(0, 0, "R5 step2", ey, ee);
    apply(16384, 0, "R5 step3", ey, ee);
    check("R5 hand y", int'(yOut), 256);
    check("R5 hand e", int'(errOut), -256);

    // R3/R4/R5: table walk
    for (int i = 0; i < NTAB; i++) apply(TBL[i][0], TBL[i][1], "R3 table", ey, ee);

    // R6: idle gap with garbage on inputs
    for (int i = 0; i < 5; i++) begin
      int yHold, eHold;
      yHold = int'(yOut); eHold = int'(errOut);
      xIn = 16'(7777 * (i + 1)); dIn = 16'(-3333 * (i + 1));
      @(negedge clk);
      check("R6 hold y", int'(yOut), yHold);
      check("R6 hold e", int'(errOut), eHold);
      check("R2 idle outValid", int'(outValid), 0);
    end
    apply(4000, -1500, "R6 resume", ey, ee);

    // R8: drive weights up, then flip input sign
    for (int i = 0; i < 120; i++) apply(32767, 32767, "R5 train", ey, ee);
    for (int i = 0; i < 4; i++) apply(-32768, 32767, "R8 flip", ey, ee);
    check("R8 e clamp", int'(errOut), 32767);
    check("R8 y nonpositive", int'(yOut <= 0), 1);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 mid y", int'(yOut), 0);
    check("R1 mid e", int'(errOut), 0);
    check("R1 mid outValid", int'(outValid), 0);
    rst = 1'b0;
    modelReset();
    apply(9000, 5000, "R1 after", ey, ee);
    check("R1 after y", int'(yOut), 0);

    // R7: identification of d = x/2 with pseudo-random input
    rst = 1'b1; @(negedge clk); rst = 1'b0; modelReset();
    lfsr = 16'hACE1;
    maxErr = 0;
    for (int n = 0; n < 4000; n++) begin
      int xv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xv = int'($signed(lfsr[13:0]));
      apply(xv, xv >>> 1, "R7 random", ey, ee);
      if (n >= 3800) begin
        int a;
        a = (ee < 0) ? -ee : ee;
        if (a > maxErr) maxErr = a;
      end
    end
    check("R7 converged", int'(maxErr < 256), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule